// File: doc/BRIEF.md
# Serial EEPROM Write-Completion Poller

After a write to a serial EEPROM on an I2C bus, the memory runs a self-timed internal programming cycle and does not acknowledge its select byte until that cycle ends. This block is the bus master that waits out that cycle. On a command it opens an attempt with a Start condition, sends the write-direction select byte for the given chip address and looks at the ninth bit slot. If the slot is high, the memory is still busy. The master then closes with a Stop, leaves the bus free for a configurable gap and tries again.

An acknowledge means the write has finished. The acknowledged select byte then serves as the first byte of the next transfer. Depending on a selector, the block then does one of three things: ends with a Stop, sends a two-byte memory address and stops, or sends the address and follows it with a repeated Start, a read-direction select and a one-byte read. If the memory has not acknowledged once a programmed number of clock cycles has passed, the block releases the bus with a Stop and raises a timeout flag. Bit timing comes from a plain clock divider. Only one master is assumed, and the clock is never stretched.

Top module: `eeprom_ack_poller`

## Requirements
- R1: After reset both bus lines are released (scl_oe = 0, sda_oe = 0), poll_done and poll_timeout are 0 and rd_data is 0.
- R2: Every attempt is a Start followed by the select byte 1,0,1,0,chip_sel[2],chip_sel[1],chip_sel[0],0 sent MSB first, with SDA released in the ninth slot.
- R3: A high ninth slot after a write select, seen before the limit, produces a Stop. Both lines then stay released for at least free_gap clock cycles before SDA falls for the next Start.
- R4: An acknowledged select with next_op 0 or 3 is followed by a Stop and then poll_done = 1.
- R5: With next_op 1, the acknowledged select is followed by mem_addr[15:8] and then mem_addr[7:0], each MSB first, then a Stop and poll_done = 1.
- R6: With next_op 2, the two address bytes are followed by a repeated Start and the select byte with its last bit set to 1. The master then reads eight bits MSB first into rd_data, leaves SDA high in the ninth slot (no acknowledge), sends a Stop and sets poll_done = 1.
- R7: A high ninth slot seen when the number of cycles since poll_go was accepted is at least wait_limit produces a Stop and poll_timeout = 1 with poll_done = 0. No further Start follows.
- R8: SDA changes while SCL is high only for a Start or a Stop, never inside a byte or its ninth slot.
- R9: poll_go is ignored while a command is in progress. poll_done and poll_timeout hold their value until the next accepted poll_go, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_go | input | 1 | Start a polling command (taken only when idle) |
| chip_sel | input | 3 | Chip address placed in the select byte |
| next_op | input | 2 | 0/3 stop, 1 address then stop, 2 address then one-byte read |
| mem_addr | input | 16 | Memory address sent after the acknowledge |
| wait_limit | input | TMO_W | Cycle budget before giving up |
| free_gap | input | GAP_W | Minimum bus-free cycles before each Start |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| poll_done | output | 1 | Command finished after an acknowledge |
| poll_timeout | output | 1 | Command abandoned at the cycle budget |
| rd_data | output | 8 | Byte read when next_op is 2 |

## Verification
A behavioural memory model on the bus refuses a chosen number of select bytes before it acknowledges. Busy counts of zero separate the direct path from the retry path. Larger counts show the per-attempt Stop, the gap timing and the repetition of the select byte. Each of the next_op values is applied, so the address bytes, the repeated Start and the read byte are present only when they should be. Random chip addresses, addresses and read bytes expose bit-order and field errors. A never-ready memory drives the timeout path. A second poll_go issued mid-command shows that a busy block does not take it.

// File: rtl/ack_poll_pkg.sv
`timescale 1ns/1ps
package ack_poll_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    localparam logic [1:0] NX_ADDR = 2'd1;
    localparam logic [1:0] NX_READ = 2'd2;

    typedef enum logic [1:0] {
        BUS_START,
        BUS_STOP,
        BUS_BIT
    } bus_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GAP,
        SQ_START,
        SQ_BYTE,
        SQ_STOP
    } seq_state_e;

    typedef enum logic [2:0] {
        BY_SEL,
        BY_AHI,
        BY_ALO,
        BY_RSEL,
        BY_RDATA
    } byte_kind_e;

    typedef enum logic [1:0] {
        END_RETRY,
        END_DONE,
        END_TIMEOUT
    } finish_e;

endpackage

// File: rtl/ack_poll_tick.sv
`timescale 1ns/1ps
module ack_poll_tick #(
    parameter int QTR_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ack_poll_bitio.sv
`timescale 1ns/1ps
module ack_poll_bitio
    import ack_poll_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     cmd_valid,
    input  bus_cmd_e cmd_kind,
    input  logic     cmd_bit,
    input  logic     sda_in,
    output logic     cmd_done,
    output logic     rx_bit,
    output logic     scl_rel,
    output logic     sda_rel
);
    typedef struct packed {
        logic       busy;
        bus_cmd_e   kind;
        logic       txb;
        logic [1:0] ph;
        logic       scl;
        logic       sda;
        logic       rx;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d        = q;
        cmd_done = 1'b0;
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy = 1'b1;
                d.kind = cmd_kind;
                d.txb  = cmd_bit;
                d.ph   = 2'd0;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            case (q.kind)
                BUS_START: begin
                    case (q.ph)
                        2'd0:    d.sda = 1'b1;
                        2'd1:    d.scl = 1'b1;
                        2'd2:    d.sda = 1'b0;
                        default: d.scl = 1'b0;
                    endcase
                end
                BUS_STOP: begin
                    case (q.ph)
                        2'd0: begin
                            d.scl = 1'b0;
                            d.sda = 1'b0;
                        end
                        2'd1:    d.scl = 1'b1;
                        2'd2:    d.sda = 1'b1;
                        default: d.scl = 1'b1;
                    endcase
                end
                default: begin
                    case (q.ph)
                        2'd0: begin
                            d.scl = 1'b0;
                            d.sda = q.txb;
                        end
                        2'd1:    d.scl = 1'b1;
                        2'd2:    d.rx  = sda_in;
                        default: d.scl = 1'b0;
                    endcase
                end
            endcase
            if (q.ph == 2'd3) begin
                d.busy   = 1'b0;
                cmd_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, kind: BUS_STOP, txb: 1'b1, ph: 2'd0,
                   scl: 1'b1, sda: 1'b1, rx: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rx_bit  = q.rx;
    assign scl_rel = q.scl;
    assign sda_rel = q.sda;

    // R8: data line moves under a high clock only for Start or Stop
    assert_sda_quiet_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl && $past(q.scl) && (q.sda != $past(q.sda)))
            |-> (q.kind == BUS_START || q.kind == BUS_STOP));
endmodule

// File: rtl/eeprom_ack_poller.sv
`timescale 1ns/1ps
module eeprom_ack_poller
    import ack_poll_pkg::*;
#(
    parameter int QTR_CYCLES = 125,
    parameter int TMO_W      = 24,
    parameter int GAP_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_go,
    input  logic [2:0]       chip_sel,
    input  logic [1:0]       next_op,
    input  logic [15:0]      mem_addr,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic [GAP_W-1:0] free_gap,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             poll_done,
    output logic             poll_timeout,
    output logic [7:0]       rd_data
);
    localparam logic [3:0] LAST_SLOT = 4'd8;

    typedef struct packed {
        seq_state_e       st;
        byte_kind_e       bk;
        finish_e          fin;
        logic [3:0]       idx;
        logic [7:0]       sh;
        logic [7:0]       rd;
        logic [2:0]       chip;
        logic [1:0]       op;
        logic [15:0]      addr;
        logic [TMO_W-1:0] limit;
        logic [TMO_W-1:0] elapsed;
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] gcnt;
        logic             done;
        logic             tmo;
    } seq_t;

    seq_t d, q;

    logic     tick;
    logic     cmd_valid, cmd_bit, cmd_done, rx_bit;
    bus_cmd_e cmd_kind;
    logic     scl_rel, sda_rel;
    logic     ack;

    ack_poll_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ack_poll_bitio u_bitio (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind),
        .cmd_bit  (cmd_bit),
        .sda_in   (sda_in),
        .cmd_done (cmd_done),
        .rx_bit   (rx_bit),
        .scl_rel  (scl_rel),
        .sda_rel  (sda_rel)
    );

    always_comb begin
        d         = q;
        cmd_valid = 1'b0;
        cmd_kind  = BUS_BIT;
        cmd_bit   = 1'b1;
        ack       = ~rx_bit;

        if (q.st != SQ_IDLE && q.elapsed != '1) d.elapsed = q.elapsed + 1'b1;

        case (q.st)
            SQ_IDLE: begin
                if (poll_go) begin
                    d.chip    = chip_sel;
                    d.op      = next_op;
                    d.addr    = mem_addr;
                    d.limit   = wait_limit;
                    d.gap     = free_gap;
                    d.gcnt    = free_gap;
                    d.elapsed = '0;
                    d.done    = 1'b0;
                    d.tmo     = 1'b0;
                    d.bk      = BY_SEL;
                    d.st      = SQ_GAP;
                end
            end
            SQ_GAP: begin
                if (q.gcnt == '0) d.st = SQ_START;
                else              d.gcnt = q.gcnt - 1'b1;
            end
            SQ_START: begin
                cmd_valid = 1'b1;
                cmd_kind  = BUS_START;
                if (cmd_done) begin
                    d.st  = SQ_BYTE;
                    d.idx = '0;
                    d.sh  = {DEV_TYPE, q.chip, (q.bk == BY_RSEL)};
                end
            end
            SQ_BYTE: begin
                cmd_valid = 1'b1;
                cmd_kind  = BUS_BIT;
                cmd_bit   = (q.bk == BY_RDATA || q.idx == LAST_SLOT) ? 1'b1 : q.sh[7];
                if (cmd_done) begin
                    if (q.idx != LAST_SLOT) begin
                        d.idx = q.idx + 1'b1;
                        d.sh  = {q.sh[6:0], 1'b0};
                        if (q.bk == BY_RDATA) d.rd = {q.rd[6:0], rx_bit};
                    end else begin
                        d.idx = '0;
                        case (q.bk)
                            BY_SEL: begin
                                if (ack) begin
                                    if (q.op == NX_ADDR || q.op == NX_READ) begin
                                        d.bk = BY_AHI;
                                        d.sh = q.addr[15:8];
                                    end else begin
                                        d.st  = SQ_STOP;
                                        d.fin = END_DONE;
                                    end
                                end else begin
                                    d.st  = SQ_STOP;
                                    d.fin = (q.elapsed >= q.limit) ? END_TIMEOUT : END_RETRY;
                                end
                            end
                            BY_AHI: begin
                                d.bk = BY_ALO;
                                d.sh = q.addr[7:0];
                            end
                            BY_ALO: begin
                                if (q.op == NX_READ) begin
                                    d.bk = BY_RSEL;
                                    d.st = SQ_START;
                                end else begin
                                    d.st  = SQ_STOP;
                                    d.fin = END_DONE;
                                end
                            end
                            BY_RSEL: d.bk = BY_RDATA;
                            default: begin
                                d.st  = SQ_STOP;
                                d.fin = END_DONE;
                            end
                        endcase
                    end
                end
            end
            SQ_STOP: begin
                cmd_valid = 1'b1;
                cmd_kind  = BUS_STOP;
                if (cmd_done) begin
                    case (q.fin)
                        END_RETRY: begin
                            d.st   = SQ_GAP;
                            d.gcnt = q.gap;
                            d.bk   = BY_SEL;
                        end
                        END_TIMEOUT: begin
                            d.st  = SQ_IDLE;
                            d.tmo = 1'b1;
                        end
                        default: begin
                            d.st   = SQ_IDLE;
                            d.done = 1'b1;
                        end
                    endcase
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, bk: BY_SEL, fin: END_RETRY, idx: '0, sh: '0,
                   rd: '0, chip: '0, op: '0, addr: '0, limit: '0,
                   elapsed: '0, gap: '0, gcnt: '0, done: 1'b0, tmo: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe       = ~scl_rel;
    assign sda_oe       = ~sda_rel;
    assign poll_done    = q.done;
    assign poll_timeout = q.tmo;
    assign rd_data      = q.rd;

    // R3: bus stays free while the gap counter runs
    assert_gap_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_GAP) |-> (scl_rel && sda_rel));

    // R4: completion only once the bus is released
    assert_done_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> (scl_rel && sda_rel && !q.tmo));

    // R7: timeout leaves the bus released and no completion
    assert_timeout_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tmo) |-> (scl_rel && sda_rel && !q.done));

    // R9: a command in progress keeps its chip address
    assert_busy_ignores_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SQ_IDLE && poll_go) |=> $stable(q.chip));
endmodule

// File: tb/eeprom_ack_poller_test.sv
`timescale 1ns/1ps
module eeprom_ack_poller_test;
    localparam int TMO_W = 24;
    localparam int GAP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             poll_go = 1'b0;
    logic [2:0]       chip_sel = '0;
    logic [1:0]       next_op = '0;
    logic [15:0]      mem_addr = '0;
    logic [TMO_W-1:0] wait_limit = '0;
    logic [GAP_W-1:0] free_gap = '0;
    logic             scl_oe, sda_oe, poll_done, poll_timeout;
    logic [7:0]       rd_data;
    logic             slave_low = 1'b0;
    logic             scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_low);

    eeprom_ack_poller #(.QTR_CYCLES(2), .TMO_W(TMO_W), .GAP_W(GAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .poll_go(poll_go), .chip_sel(chip_sel),
        .next_op(next_op), .mem_addr(mem_addr), .wait_limit(wait_limit),
        .free_gap(free_gap), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .poll_done(poll_done), .poll_timeout(poll_timeout), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // memory model state
    int       busy_left = 0;
    logic [7:0] exp_sel = '0;
    logic [7:0] rd_byte = '0;
    int       nb = 0, byte_no = 0;
    logic [7:0] cur = '0;
    bit       reading = 0, pending = 0;
    int       starts = 0, stops = 0, sel_seen = 0, sel_bad = 0, addr_cnt = 0;
    logic [7:0] cap_hi = '0, cap_lo = '0, rsel_byte = '0;
    logic     master_ack = 1'b0;
    int       viol = 0;
    int       last_stop = -1, min_gap = 1000000;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 180000 && !finished) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 180000);
            summary();
            $finish;
        end
    end

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        starts = starts + 1;
        nb = 0; byte_no = 0; reading = 0; pending = 0;
        if (last_stop >= 0 && (cyc - last_stop) < min_gap) min_gap = cyc - last_stop;
    end

    always @(posedge sda_line) if (scl_line === 1'b1) begin
        stops = stops + 1;
        last_stop = cyc;
        nb = 0;
    end

    always @(sda_line) if (scl_line === 1'b1 && nb != 0) viol = viol + 1;

    always @(posedge scl_line) begin
        if (nb < 8) begin
            cur = {cur[6:0], sda_line};
            nb  = nb + 1;
        end else if (nb == 8) begin
            if (reading) master_ack = sda_line;
            nb = 9;
        end
    end

    always @(negedge scl_line) begin
        if (nb == 8) begin
            if (reading) slave_low = 1'b0;
            else begin
                bit a;
                a = 1'b1;
                if (byte_no == 0) begin
                    if (cur[0] == 1'b0) begin
                        sel_seen = sel_seen + 1;
                        if (cur != exp_sel) sel_bad = sel_bad + 1;
                        if (busy_left > 0) begin
                            a = 1'b0;
                            busy_left = busy_left - 1;
                        end
                    end else begin
                        rsel_byte = cur;
                        pending = 1;
                    end
                end else begin
                    addr_cnt = addr_cnt + 1;
                    if (byte_no == 1) cap_hi = cur;
                    else cap_lo = cur;
                end
                slave_low = a;
            end
        end else if (nb == 9) begin
            slave_low = 1'b0;
            nb = 0;
            byte_no = byte_no + 1;
            if (reading) reading = 0;
            else if (pending) begin
                reading = 1;
                pending = 0;
            end
        end
        if (reading && nb < 8) slave_low = ~rd_byte[7 - nb];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel_of(input logic [2:0] c);
        return {4'b1010, c, 1'b0};
    endfunction

    function automatic int starts_of(input int b, input logic [1:0] op);
        return b + 1 + ((op == 2'd2) ? 1 : 0);
    endfunction

    task automatic run_op(input logic [2:0] c, input logic [1:0] op, input logic [15:0] a,
                          input int b, input logic [7:0] rb, input int gap,
                          input logic [TMO_W-1:0] lim, input bit expect_to, input bit poke);
        int t0;
        busy_left = b; exp_sel = sel_of(c); rd_byte = rb;
        starts = 0; stops = 0; sel_seen = 0; sel_bad = 0; addr_cnt = 0;
        viol = 0; min_gap = 1000000; master_ack = 1'b0; rsel_byte = '0;
        @(negedge clk);
        chip_sel = c; next_op = op; mem_addr = a; free_gap = GAP_W'(gap); wait_limit = lim;
        poll_go = 1'b1;
        @(negedge clk);
        poll_go = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            chip_sel = ~c; poll_go = 1'b1;
            @(negedge clk);
            poll_go = 1'b0;
        end
        t0 = cyc;
        while (!(poll_done || poll_timeout)) begin
            @(negedge clk);
            if (cyc - t0 > 60000) break;
        end
        repeat (4) @(negedge clk);
        if (expect_to) begin
            int s;
            chk(poll_timeout == 1'b1, "R7 timeout flag", poll_timeout, 1);
            chk(poll_done == 1'b0, "R7 done stays low", poll_done, 0);
            s = starts;
            repeat (400) @(negedge clk);
            chk(starts == s, "R7 no Start after timeout", starts, s);
            chk(!scl_oe && !sda_oe, "R7 bus released", {scl_oe, sda_oe}, 0);
            chk(sel_bad == 0, "R2 select byte", sel_bad, 0);
            busy_left = 0;
        end else begin
            chk(poll_done == 1'b1 && poll_timeout == 1'b0, "R4 done flag", {poll_done, poll_timeout}, 2);
            chk(sel_bad == 0, "R2 select byte value", sel_bad, 0);
            chk(sel_seen == b + 1, "R2 attempts", sel_seen, b + 1);
            chk(stops == b + 1, "R3 one Stop per attempt", stops, b + 1);
            chk(starts == starts_of(b, op), "R6 Start count", starts, starts_of(b, op));
            if (b > 0) chk(min_gap >= gap, "R3 bus free gap", min_gap, gap);
            chk(viol == 0, "R8 SDA steady while SCL high", viol, 0);
            if (op == 2'd1 || op == 2'd2) begin
                chk(addr_cnt == 2, "R5 two address bytes", addr_cnt, 2);
                chk({cap_hi, cap_lo} == a, "R5 address order", {cap_hi, cap_lo}, a);
            end else begin
                chk(addr_cnt == 0, "R4 no address bytes", addr_cnt, 0);
            end
            if (op == 2'd2) begin
                chk(rsel_byte == (sel_of(c) | 8'd1), "R6 read select", rsel_byte, sel_of(c) | 8'd1);
                chk(rd_data == rb, "R6 read byte", rd_data, rb);
                chk(master_ack == 1'b1, "R6 master no-ack", master_ack, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nb = 0; viol = 0; slave_low = 1'b0;
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!poll_done && !poll_timeout, "R1 flags low", {poll_done, poll_timeout}, 0);
        chk(rd_data == 8'd0, "R1 rd_data zero", rd_data, 0);

        // directed corners
        run_op(3'd5, 2'd0, 16'h1234, 0, 8'h00, 3, '1, 0, 0);
        run_op(3'd2, 2'd3, 16'h0000, 2, 8'h00, 10, '1, 0, 0);
        run_op(3'd7, 2'd1, 16'hA55A, 1, 8'h00, 0, '1, 0, 0);
        run_op(3'd1, 2'd2, 16'h7FC3, 3, 8'hB6, 0, '1, 0, 0);
        run_op(3'd4, 2'd2, 16'hFFFF, 0, 8'h01, 20, '1, 0, 0);
        // R9: second poll_go while busy must be ignored; flag then holds
        run_op(3'd6, 2'd1, 16'h0F0F, 2, 8'h00, 5, '1, 0, 1);
        repeat (50) @(negedge clk);
        chk(poll_done == 1'b1, "R9 done held", poll_done, 1);
        // R7 never-ready memory
        run_op(3'd3, 2'd0, 16'h0000, 100000, 8'h00, 4, 24'd150, 1, 0);
        // R9 next accepted command clears the timeout flag
        @(negedge clk);
        poll_go = 1'b1; chip_sel = 3'd0; next_op = 2'd0; wait_limit = '1;
        exp_sel = sel_of(3'd0);
        @(negedge clk);
        poll_go = 1'b0;
        chk(!poll_timeout && !poll_done, "R9 flags cleared", {poll_done, poll_timeout}, 0);
        while (!(poll_done || poll_timeout)) @(negedge clk);

        for (int i = 0; i < 25; i++) begin
            run_op(3'($urandom % 8), 2'($urandom % 4), 16'($urandom), int'($urandom % 4),
                   8'($urandom), int'($urandom % 24), '1, 0, 0);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule